// File: doc/BRIEF.md
# Station Address CAM Filter

This block decides whether an incoming frame's destination address belongs to this station. It keeps a table of sixteen 48-bit station addresses and a 16-bit mask that enables the entries one by one. Each destination address presented with a strobe is classified, one clock later, as accepted unicast, accepted multicast, accepted broadcast or rejected. Three mode inputs open the filter wider: promiscuous, all-multicast and broadcast accept.

The table is filled by a load sequencer. A load request carries an entry count. The sequencer then takes 16-bit words from a valid/ready stream, four words per entry, followed by one word that becomes the enable mask. At the end it pulses a done flag. A register-style read path returns any 16-bit slice of any entry, but only while the controller's hold (reset) input is asserted. Writes to that read path are accepted at the pins and have no effect.

Top module: `cam_addr_filter`

## Requirements
- R1: After synchronous reset, `ld_word_ready`, `load_done`, `res_valid` and `rd_data` are low and all entries are disabled, so with every mode off any address is rejected.
- R2: A load takes its entry count from `load_count` (5 bits). Each entry uses four words: the first is discarded, and the next three supply address bytes {1,0}, {3,2} and {5,4}, with the low byte of each word as the lower-numbered byte. Entries are filled from index 0 upward.
- R3: After the last entry, one more word is taken as the enable mask, where bit i enables entry i. A count of zero loads only the mask.
- R4: `load_done` is a one-cycle pulse in the cycle after the mask word is accepted, and `ld_word_ready` is low from that same cycle.
- R5: A load request that arrives while a load is in progress is ignored.
- R6: `ld_word_ready` is high exactly while a load is in progress. A cycle with `ld_word_valid` low does not advance the load.
- R7: `res_valid` is high exactly one clock after each cycle with `da_valid` high, and at no other time.
- R8: Address byte 0 is `da[7:0]` and byte 5 is `da[47:40]`. Bit `da[0]` is the group bit. With promiscuous mode on and the group bit clear, the result is unicast (code 1) whatever the table holds.
- R9: With all-multicast on and the group bit set, the result is multicast (code 2). This rule wins over broadcast.
- R10: With broadcast accept on and all 48 bits set, and the earlier rules not applying, the result is broadcast (code 3). With broadcast accept off, such an address is rejected (code 0) unless an entry matches.
- R11: Otherwise, a match with an enabled entry gives unicast (code 1). A disabled entry never matches, and with no match the result is reject (code 0).
- R12: `rd_data` returns the entry at `rd_ptr`, one clock later: `rd_sel` 0, 1 and 2 select bytes {1,0}, {3,2} and {5,4}, and `rd_sel` 3 returns zero. While `ctrl_hold` is low, `rd_data` is zero.
- R13: Port writes (`port_wr_en`, `port_wr_sel`, `port_wr_data`) change neither the entries nor the classification.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| mode_promisc | input | 1 | Accept every individual address |
| mode_allmulti | input | 1 | Accept every group address |
| mode_bcast | input | 1 | Accept the all-ones address |
| ctrl_hold | input | 1 | Controller held in reset; enables readback |
| load_req | input | 1 | Start a table load |
| load_count | input | 5 | Number of entries to load |
| ld_word_valid | input | 1 | Load word is valid |
| ld_word | input | 16 | Load word |
| ld_word_ready | output | 1 | Loader accepts a word (load in progress) |
| load_done | output | 1 | One-cycle pulse at the end of a load |
| da_valid | input | 1 | Destination address strobe |
| da | input | 48 | Destination address, byte 0 in bits 7:0 |
| res_valid | output | 1 | Classification result valid |
| res_class | output | 2 | 0 reject, 1 unicast, 2 multicast, 3 broadcast |
| rd_ptr | input | 4 | Entry selected for readback |
| rd_sel | input | 2 | 16-bit slice selected for readback |
| rd_data | output | 16 | Readback data |
| port_wr_en | input | 1 | Write strobe to the readback ports (ignored) |
| port_wr_sel | input | 2 | Readback port chosen for the write (ignored) |
| port_wr_data | input | 16 | Write data (ignored) |

## Verification
The bench targets the priority order among the accept rules. An all-ones address with both all-multicast and broadcast enabled must be reported as multicast, and a design with the order swapped reports broadcast instead. It loads a table in which an entry holds a valid address but is masked off: a filter that ignores the mask accepts that address. The load stream has bubbles and a stray load request in the middle. A loader that counts idle cycles, or that restarts on the second request, places addresses at the wrong indices, and readback exposes that. It also covers a load with count zero, where only the mask changes, and port writes made while readback is open, which a careless decoder would let through to the table.

// File: rtl/cam_filt_pkg.sv
package cam_filt_pkg;
  localparam int ADDR_W = 48;
  localparam int WORD_W = 16;
  localparam int SLICES = ADDR_W / WORD_W;

  typedef enum logic [1:0] {
    CLS_REJECT = 2'd0,
    CLS_UCAST  = 2'd1,
    CLS_MCAST  = 2'd2,
    CLS_BCAST  = 2'd3
  } cls_e;

  typedef enum logic [1:0] {
    LD_IDLE  = 2'd0,
    LD_ENTRY = 2'd1,
    LD_MASK  = 2'd2
  } ld_state_e;
endpackage

// File: rtl/cam_loader.sv
module cam_loader
  import cam_filt_pkg::*;
#(
  parameter int N_ENT = 16,
  parameter int CNT_W = 5,
  localparam int IDX_W = $clog2(N_ENT)
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic                      load_req,
  input  logic [CNT_W-1:0]          load_count,
  input  logic                      wvalid,
  input  logic [WORD_W-1:0]         wdata,
  output logic                      wready,
  output logic                      ent_we,
  output logic [IDX_W-1:0]          ent_idx,
  output logic [ADDR_W-1:0]         ent_data,
  output logic                      mask_we,
  output logic [N_ENT-1:0]          mask_data,
  output logic                      load_done
);
  localparam int STAGE_W = ADDR_W - WORD_W;

  ld_state_e            state_q;
  logic [CNT_W-1:0]     left_q;
  logic [IDX_W-1:0]     idx_q;
  logic [1:0]           wsel_q;
  logic [STAGE_W-1:0]   stage_q;
  logic                 done_q;
  logic                 accept;

  always_comb begin
    wready    = (state_q != LD_IDLE);
    accept    = wready && wvalid;
    ent_we    = accept && (state_q == LD_ENTRY) && (wsel_q == 2'd3);
    mask_we   = accept && (state_q == LD_MASK);
    ent_idx   = idx_q;
    ent_data  = {wdata, stage_q};
    mask_data = wdata[N_ENT-1:0];
    load_done = done_q;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= LD_IDLE;
      left_q  <= '0;
      idx_q   <= '0;
      wsel_q  <= '0;
      stage_q <= '0;
      done_q  <= 1'b0;
    end else begin
      done_q <= mask_we;
      case (state_q)
        LD_IDLE: begin
          if (load_req) begin
            left_q  <= load_count;
            idx_q   <= '0;
            wsel_q  <= '0;
            state_q <= (load_count == '0) ? LD_MASK : LD_ENTRY;
          end
        end
        LD_ENTRY: begin
          if (accept) begin
            wsel_q <= wsel_q + 2'd1;
            if (wsel_q == 2'd1) stage_q[WORD_W-1:0] <= wdata;
            if (wsel_q == 2'd2) stage_q[STAGE_W-1:WORD_W] <= wdata;
            if (wsel_q == 2'd3) begin
              idx_q  <= idx_q + 1'b1;
              left_q <= left_q - 1'b1;
              if (left_q == {{(CNT_W-1){1'b0}}, 1'b1}) state_q <= LD_MASK;
            end
          end
        end
        LD_MASK: begin
          if (accept) state_q <= LD_IDLE;
        end
        default: state_q <= LD_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/cam_table.sv
module cam_table
  import cam_filt_pkg::*;
#(
  parameter int N_ENT = 16,
  localparam int IDX_W = $clog2(N_ENT)
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  we,
  input  logic [IDX_W-1:0]      widx,
  input  logic [ADDR_W-1:0]     wdata,
  input  logic                  mask_we,
  input  logic [N_ENT-1:0]      mask_in,
  input  logic [ADDR_W-1:0]     probe,
  output logic                  hit,
  input  logic [IDX_W-1:0]      rd_ptr,
  input  logic [1:0]            rd_sel,
  input  logic                  rd_allow,
  output logic [WORD_W-1:0]     rd_data
);
  logic [ADDR_W-1:0] ent_q [N_ENT];
  logic [N_ENT-1:0]  mask_q;
  logic [N_ENT-1:0]  hit_vec;
  logic [ADDR_W-1:0] rd_ent;

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < N_ENT; i++) ent_q[i] <= '0;
      mask_q <= '0;
    end else begin
      if (we) ent_q[widx] <= wdata;
      if (mask_we) mask_q <= mask_in;
    end
  end

  for (genvar g = 0; g < N_ENT; g++) begin : g_cmp
    assign hit_vec[g] = mask_q[g] && (ent_q[g] == probe);
  end

  assign hit    = |hit_vec;
  assign rd_ent = ent_q[rd_ptr];

  always_ff @(posedge clk) begin
    if (rst || !rd_allow) begin
      rd_data <= '0;
    end else begin
      case (rd_sel)
        2'd0:    rd_data <= rd_ent[WORD_W-1:0];
        2'd1:    rd_data <= rd_ent[2*WORD_W-1:WORD_W];
        2'd2:    rd_data <= rd_ent[3*WORD_W-1:2*WORD_W];
        default: rd_data <= '0;
      endcase
    end
  end
endmodule

// File: rtl/cam_classifier.sv
module cam_classifier
  import cam_filt_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              dv,
  input  logic [ADDR_W-1:0] da,
  input  logic              promisc,
  input  logic              allmulti,
  input  logic              bcast_en,
  input  logic              cam_hit,
  output logic              res_valid,
  output logic [1:0]        res_class
);
  cls_e next_cls;
  logic grp;
  logic all_ones;

  always_comb begin
    grp      = da[0];
    all_ones = &da;
    if (promisc && !grp)            next_cls = CLS_UCAST;
    else if (allmulti && grp)       next_cls = CLS_MCAST;
    else if (bcast_en && all_ones)  next_cls = CLS_BCAST;
    else if (cam_hit)               next_cls = CLS_UCAST;
    else                            next_cls = CLS_REJECT;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      res_valid <= 1'b0;
      res_class <= CLS_REJECT;
    end else begin
      res_valid <= dv;
      res_class <= next_cls;
    end
  end
endmodule

// File: rtl/cam_addr_filter.sv
module cam_addr_filter
  import cam_filt_pkg::*;
#(
  parameter int N_ENT = 16,
  parameter int CNT_W = 5,
  localparam int IDX_W = $clog2(N_ENT)
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               mode_promisc,
  input  logic               mode_allmulti,
  input  logic               mode_bcast,
  input  logic               ctrl_hold,
  input  logic               load_req,
  input  logic [CNT_W-1:0]   load_count,
  input  logic               ld_word_valid,
  input  logic [15:0]        ld_word,
  output logic               ld_word_ready,
  output logic               load_done,
  input  logic               da_valid,
  input  logic [47:0]        da,
  output logic               res_valid,
  output logic [1:0]         res_class,
  input  logic [IDX_W-1:0]   rd_ptr,
  input  logic [1:0]         rd_sel,
  output logic [15:0]        rd_data,
  input  logic               port_wr_en,
  input  logic [1:0]         port_wr_sel,
  input  logic [15:0]        port_wr_data
);
  logic              ent_we;
  logic [IDX_W-1:0]  ent_idx;
  logic [ADDR_W-1:0] ent_data;
  logic              mask_we;
  logic [N_ENT-1:0]  mask_data;
  logic              cam_hit;
  logic              unused_port_wr;

  // The readback ports are read-only; writes reach the pins and stop here.
  assign unused_port_wr = ^{port_wr_en, port_wr_sel, port_wr_data};

  cam_loader #(.N_ENT(N_ENT), .CNT_W(CNT_W)) loader_i (
    .clk        (clk),
    .rst        (rst),
    .load_req   (load_req),
    .load_count (load_count),
    .wvalid     (ld_word_valid),
    .wdata      (ld_word),
    .wready     (ld_word_ready),
    .ent_we     (ent_we),
    .ent_idx    (ent_idx),
    .ent_data   (ent_data),
    .mask_we    (mask_we),
    .mask_data  (mask_data),
    .load_done  (load_done)
  );

  cam_table #(.N_ENT(N_ENT)) table_i (
    .clk      (clk),
    .rst      (rst),
    .we       (ent_we),
    .widx     (ent_idx),
    .wdata    (ent_data),
    .mask_we  (mask_we),
    .mask_in  (mask_data),
    .probe    (da),
    .hit      (cam_hit),
    .rd_ptr   (rd_ptr),
    .rd_sel   (rd_sel),
    .rd_allow (ctrl_hold),
    .rd_data  (rd_data)
  );

  cam_classifier class_i (
    .clk       (clk),
    .rst       (rst),
    .dv        (da_valid),
    .da        (da),
    .promisc   (mode_promisc),
    .allmulti  (mode_allmulti),
    .bcast_en  (mode_bcast),
    .cam_hit   (cam_hit),
    .res_valid (res_valid),
    .res_class (res_class)
  );
endmodule

module cam_addr_filter_chk (
  input logic        clk,
  input logic        rst,
  input logic        mode_promisc,
  input logic        mode_allmulti,
  input logic        mode_bcast,
  input logic        ctrl_hold,
  input logic        ld_word_ready,
  input logic        load_done,
  input logic        da_valid,
  input logic [47:0] da,
  input logic        res_valid,
  input logic [1:0]  res_class,
  input logic [15:0] rd_data
);
  // R7
  res_follows_strobe_chk: assert property (@(posedge clk) disable iff (rst)
    da_valid |=> res_valid);
  // R7
  no_spurious_res_chk: assert property (@(posedge clk) disable iff (rst)
    !da_valid |=> !res_valid);
  // R8
  promisc_ucast_chk: assert property (@(posedge clk) disable iff (rst)
    (da_valid && mode_promisc && !da[0]) |=> (res_class == 2'd1));
  // R9
  allmulti_mcast_chk: assert property (@(posedge clk) disable iff (rst)
    (da_valid && mode_allmulti && da[0]) |=> (res_class == 2'd2));
  // R10
  bcast_accept_chk: assert property (@(posedge clk) disable iff (rst)
    (da_valid && mode_bcast && !mode_allmulti && (&da)) |=> (res_class == 2'd3));
  // R12
  rd_gated_chk: assert property (@(posedge clk) disable iff (rst)
    !ctrl_hold |=> (rd_data == 16'h0000));
  // R4
  done_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    load_done |=> !load_done);
  // R4
  done_idle_chk: assert property (@(posedge clk) disable iff (rst)
    load_done |-> !ld_word_ready);
endmodule

bind cam_addr_filter cam_addr_filter_chk chk_i (.*);

// File: tb/cam_addr_filter_tb.sv
module cam_addr_filter_tb_top;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        mode_promisc = 0, mode_allmulti = 0, mode_bcast = 0, ctrl_hold = 0;
  logic        load_req = 0;
  logic [4:0]  load_count = '0;
  logic        ld_word_valid = 0;
  logic [15:0] ld_word = '0;
  logic        ld_word_ready, load_done;
  logic        da_valid = 0;
  logic [47:0] da = '0;
  logic        res_valid;
  logic [1:0]  res_class;
  logic [3:0]  rd_ptr = '0;
  logic [1:0]  rd_sel = '0;
  logic [15:0] rd_data;
  logic        port_wr_en = 0;
  logic [1:0]  port_wr_sel = '0;
  logic [15:0] port_wr_data = '0;

  always #(CLK_PERIOD/2) clk = ~clk;

  cam_addr_filter dut_i (.*);

  int    n_checks = 0;
  int    n_fails  = 0;
  string cur_req  = "R1";
  bit    started  = 0;

  // ---------------- behavioural reference model ----------------
  logic [47:0] m_tbl [16];
  logic [15:0] m_mask;
  bit          m_busy, m_mask_phase;
  int          m_left, m_ent;
  logic [15:0] m_words [$];
  logic        e_rv, e_done;
  logic [1:0]  e_cls;
  logic [15:0] e_rd;

  function automatic logic [1:0] ref_cls(input logic [47:0] a);
    if (mode_promisc && !a[0]) return 2'd1;
    if (mode_allmulti && a[0]) return 2'd2;
    if (mode_bcast && a == {48{1'b1}}) return 2'd3;
    for (int i = 0; i < 16; i++)
      if (m_mask[i] && m_tbl[i] == a) return 2'd1;
    return 2'd0;
  endfunction

  function automatic logic [15:0] ref_rd();
    if (!ctrl_hold || rd_sel == 2'd3) return 16'h0;
    return m_tbl[rd_ptr][16*rd_sel +: 16];
  endfunction

  always @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < 16; i++) m_tbl[i] = '0;
      m_mask = '0; m_busy = 0; m_mask_phase = 0; m_left = 0; m_ent = 0;
      m_words.delete();
      e_rv = 0; e_done = 0; e_cls = 0; e_rd = 0;
    end else begin
      e_rv   = da_valid;
      e_cls  = ref_cls(da);
      e_rd   = ref_rd();
      e_done = 0;
      if (m_busy) begin
        if (ld_word_valid) begin
          if (m_mask_phase) begin
            m_mask = ld_word; m_busy = 0; e_done = 1;
          end else begin
            m_words.push_back(ld_word);
            if (m_words.size() == 4) begin
              m_tbl[m_ent] = {m_words[3], m_words[2], m_words[1]};
              m_ent = (m_ent + 1) % 16;
              m_left--;
              m_words.delete();
              if (m_left == 0) m_mask_phase = 1;
            end
          end
        end
      end else if (load_req) begin
        m_busy = 1; m_left = load_count; m_ent = 0;
        m_mask_phase = (load_count == 0);
        m_words.delete();
      end
    end
  end

  task automatic report(input string tag, input logic [47:0] act, input logic [47:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fails++;
      $display("FAIL %s: actual %0h expected %0h at %0t", tag, act, exp, $time);
    end
  endtask

  // compare against the model on every clock, away from the active edge
  always @(negedge clk) begin
    if (started) begin
      report({cur_req, " res_valid"}, res_valid, e_rv);
      report({cur_req, " load_done"}, load_done, e_done);
      report({cur_req, " ready"}, ld_word_ready, m_busy);
      report({cur_req, " rd_data"}, rd_data, e_rd);
      if (e_rv) report({cur_req, " res_class"}, res_class, e_cls);
    end
  end

  // ---------------- stimulus ----------------
  logic [47:0] ld_list [16];

  task automatic do_load(input int n, input logic [15:0] msk, input int bubble_every,
                         input bit stray_req);
    load_req = 1; load_count = n[4:0];
    @(negedge clk);
    load_req = 0;
    report("R6 ready on start", ld_word_ready, 1);
    for (int e = 0; e < n; e++) begin
      for (int w = 0; w < 4; w++) begin
        ld_word_valid = 1;
        ld_word = (w == 0) ? (16'hBAD0 ^ e[15:0]) : ld_list[e][16*(w-1) +: 16];
        if (stray_req && e == 1 && w == 0) begin
          load_req = 1; load_count = 5'd2;   // R5 stray request mid-load
        end
        @(negedge clk);
        load_req = 0;
        if (bubble_every != 0 && ((e*4 + w) % bubble_every) == 0) begin
          ld_word_valid = 0; ld_word = 16'hFFFF;   // R6 idle cycle
          @(negedge clk);
        end
      end
    end
    ld_word_valid = 1; ld_word = msk;
    @(negedge clk);
    ld_word_valid = 0;
    report("R4 done pulse", load_done, 1);
    report("R4 ready low", ld_word_ready, 0);
    @(negedge clk);
    report("R4 done single", load_done, 0);
  endtask

  task automatic classify(input logic [47:0] a, input logic [1:0] exp, input string tag);
    da_valid = 1; da = a;
    @(negedge clk);
    da_valid = 0;
    report({tag, " valid"}, res_valid, 1);
    report({tag, " class"}, res_class, exp);
  endtask

  task automatic readb(input logic [3:0] p, input logic [1:0] s,
                       input logic [15:0] exp, input string tag);
    rd_ptr = p; rd_sel = s;
    @(negedge clk);
    report(tag, rd_data, exp);
  endtask

  task automatic finish_run();
    $display("  [TB] %0d tests run, %0d failed", n_checks, n_fails);
    $finish;
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    n_checks++; n_fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  localparam logic [47:0] A0 = 48'h6655_4433_2210;
  localparam logic [47:0] A1 = 48'h0A0B_0C0D_0E02;
  localparam logic [47:0] A2 = 48'hAABB_CCDD_EE40;
  localparam logic [47:0] UC = 48'h1234_5678_9A00;
  localparam logic [47:0] MC = 48'h0100_005E_0001;
  localparam logic [47:0] BC = {48{1'b1}};

  initial begin
    repeat (3) @(negedge clk);
    started = 1;
    rst = 0;
    // R1 reset state
    cur_req = "R1";
    report("R1 ready", ld_word_ready, 0);
    report("R1 done", load_done, 0);
    report("R1 res_valid", res_valid, 0);
    report("R1 rd_data", rd_data, 0);
    classify(A0, 2'd0, "R1 empty table");
    classify(48'h0, 2'd0, "R1 zero address");

    // R2 R3 R5 R6: three entries, entry 1 masked off, bubbles and stray request
    cur_req = "R2";
    ld_list[0] = A0; ld_list[1] = A1; ld_list[2] = A2;
    do_load(3, 16'h0005, 3, 1'b1);
    cur_req = "R11";
    classify(A0, 2'd1, "R11 entry0 hit");
    classify(A1, 2'd0, "R11 disabled entry");
    classify(A2, 2'd1, "R11 entry2 hit");
    classify(UC, 2'd0, "R11 no match");

    cur_req = "R12";
    ctrl_hold = 1;
    @(negedge clk);
    readb(4'd2, 2'd0, 16'hEE40, "R12 slice0 / R2 byte order");
    readb(4'd2, 2'd1, 16'hCCDD, "R12 slice1");
    readb(4'd2, 2'd2, 16'hAABB, "R12 slice2");
    readb(4'd1, 2'd0, 16'h0E02, "R5 entry1 kept");
    readb(4'd0, 2'd2, 16'h6655, "R2 entry0");
    readb(4'd3, 2'd0, 16'h0000, "R5 entry3 untouched");
    readb(4'd2, 2'd3, 16'h0000, "R12 sel3 zero");

    cur_req = "R13";
    port_wr_en = 1; port_wr_sel = 2'd0; port_wr_data = 16'hFFFF; rd_ptr = 4'd2; rd_sel = 2'd0;
    @(negedge clk);
    port_wr_sel = 2'd2;
    @(negedge clk);
    port_wr_en = 0;
    readb(4'd2, 2'd0, 16'hEE40, "R13 slice0 unchanged");
    readb(4'd2, 2'd2, 16'hAABB, "R13 slice2 unchanged");
    classify(A2, 2'd1, "R13 match unchanged");

    cur_req = "R12";
    ctrl_hold = 0;
    @(negedge clk);
    readb(4'd2, 2'd0, 16'h0000, "R12 gated");

    cur_req = "R8";
    mode_promisc = 1;
    classify(UC, 2'd1, "R8 promisc unicast");
    classify(MC, 2'd0, "R8 promisc group rejected");
    mode_promisc = 0;

    cur_req = "R9";
    mode_allmulti = 1;
    classify(MC, 2'd2, "R9 multicast");
    mode_bcast = 1;
    classify(BC, 2'd2, "R9 beats broadcast");
    classify(UC, 2'd0, "R9 unicast not widened");
    mode_allmulti = 0;

    cur_req = "R10";
    classify(BC, 2'd3, "R10 broadcast");
    mode_bcast = 0;
    classify(BC, 2'd0, "R10 broadcast off");

    cur_req = "R7";
    da_valid = 1; da = A0;
    @(negedge clk);
    da = A1;
    @(negedge clk);
    da_valid = 0;
    report("R7 back-to-back valid", res_valid, 1);
    report("R7 back-to-back class", res_class, 2'd0);
    @(negedge clk);
    report("R7 valid drops", res_valid, 0);

    cur_req = "R3";
    do_load(0, 16'h0001, 0, 1'b0);
    classify(A0, 2'd1, "R3 mask-only keeps entry0");
    classify(A2, 2'd0, "R3 entry2 now disabled");

    cur_req = "R2";
    for (int i = 0; i < 16; i++)
      ld_list[i] = 48'hC0FF_EE00_0000 | (48'(i) << 24) | 48'(2*i);
    do_load(16, 16'h7FFF, 0, 1'b0);
    classify(ld_list[0],  2'd1, "R2 full table entry0");
    classify(ld_list[14], 2'd1, "R2 full table entry14");
    classify(ld_list[15], 2'd0, "R11 entry15 masked");
    ctrl_hold = 1;
    readb(4'd15, 2'd0, 16'h001E, "R2 entry15 readback");
    ctrl_hold = 0;
    @(negedge clk);

    finish_run();
  end
endmodule